// File: doc/BRIEF.md
# Masked Identifier Acceptance Filter with Receive Queue

This block sits behind a CAN frame decoder and decides, frame by frame, whether a received frame is kept. It holds a table of identifier/mask pairs. A frame is kept when one of the occupied entries matches it under that entry's mask. If the table is empty, every frame is kept. Kept frames go into a small first-in first-out queue, and a consumer drains that queue in arrival order through a show-ahead read port.

Software, or a controller, maintains the table through a one-command-per-cycle configuration port. It can add an identifier/mask pair and learn which slot the pair landed in. It can remove a pair by naming its identifier. It can read any slot back. A slot whose identifier is zero is free, so zero can never be used as a filter identifier.

The match search is combinational, so a frame presented with `rx_valid` is decided and stored in the same clock edge. No back-pressure is needed. A kept frame that finds the queue full is discarded and raises a one-cycle overrun flag.

Top module: `rx_accept_ring`

## Requirements
- R1: After reset the queue is empty (`q_valid`=0, `q_count`=0), `cfg_ack` and `rx_overrun` are 0, and every table slot reads back identifier 0 and mask 0.
- R2: The frame word is 32 bits: bit 31 is the extended-format flag, bit 30 is the remote-request flag and bits 28:0 hold the identifier. It is compared as a whole word. A frame matches an occupied slot when (mask AND slot id) equals (mask AND frame word). The kept frame carries in `q_slot` the lowest-numbered matching slot.
- R3: When no slot is occupied, every frame is kept with `q_slot`=0. When at least one slot is occupied, a frame that matches none is dropped without raising `rx_overrun`.
- R4: Add (`cfg_op`=1) behaves as follows. An identifier that is already present answers with its existing slot, `cfg_err`=0 and no table change. Otherwise the pair is written into the lowest free slot, and that slot index is returned. With all 16 slots occupied, or with identifier 0, the block answers `cfg_err`=1 and `cfg_slot`=0.
- R5: Remove (`cfg_op`=2) clears both identifier and mask of the slot holding the given identifier and returns that slot index with `cfg_err`=0. If no slot holds it, or it is 0, the block answers `cfg_err`=1 and leaves the table unchanged.
- R6: The queue holds 8 frames and returns them in arrival order, each with its identifier word, length code, data bytes and slot. Its read and write positions wrap modulo 8, and `q_count` gives the fill level.
- R7: A kept frame that arrives while `q_count`=8 is discarded. `rx_overrun` is then 1 for exactly the following cycle, and the queue contents are unchanged.
- R8: When a frame is stored and a frame is popped in the same cycle, both take effect and `q_count` is unchanged.
- R9: Read (`cfg_op`=3) returns the identifier and mask of slot `cfg_sel` on `cfg_rd_id`/`cfg_rd_mask`, with `cfg_slot`=`cfg_sel`.
- R10: Every non-idle command is answered with `cfg_ack`=1 in the cycle after it. A frame presented in the same cycle as a command is judged against the table as it was before that command. A pop while the queue is empty is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_op | input | 2 | Command: 0 idle, 1 add, 2 remove, 3 read |
| cfg_id | input | 32 | Identifier for add/remove |
| cfg_mask | input | 32 | Mask for add |
| cfg_sel | input | 4 | Slot to read |
| cfg_ack | output | 1 | Command answered (one cycle after it) |
| cfg_err | output | 1 | Command failed |
| cfg_slot | output | 4 | Slot index of the answer |
| cfg_rd_id | output | 32 | Identifier read back |
| cfg_rd_mask | output | 32 | Mask read back |
| rx_valid | input | 1 | Decoded frame present |
| rx_id | input | 32 | Frame word (flags and identifier) |
| rx_dlc | input | 4 | Length code |
| rx_data | input | 64 | Eight data bytes |
| rx_overrun | output | 1 | Kept frame lost to a full queue |
| q_valid | output | 1 | Queue head holds a frame |
| q_pop | input | 1 | Remove the head frame |
| q_id | output | 32 | Head frame word |
| q_dlc | output | 4 | Head length code |
| q_data | output | 64 | Head data bytes |
| q_slot | output | 4 | Slot that kept the head frame |
| q_count | output | 4 | Frames held |

## Verification
The bench builds the block with its default 16 slots and 8 queue entries. At this size a completely full table, every slot index, a full queue with overrun and several wraps of the queue positions are all reachable within a short run. A 128-word sweep over all four flag combinations runs against a table with overlapping masks and shadowed entries. The expected acceptance and slot for each word are computed arithmetically.

// File: rtl/rx_accept_ring.sv
module rx_accept_ring #(
  parameter int NSLOT = 16,
  parameter int DEPTH = 8,
  parameter int IDW   = 32,
  parameter int LENW  = 4,
  parameter int DATW  = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   cfg_op,
  input  logic [IDW-1:0]               cfg_id,
  input  logic [IDW-1:0]               cfg_mask,
  input  logic [$clog2(NSLOT)-1:0]     cfg_sel,
  output logic                         cfg_ack,
  output logic                         cfg_err,
  output logic [$clog2(NSLOT)-1:0]     cfg_slot,
  output logic [IDW-1:0]               cfg_rd_id,
  output logic [IDW-1:0]               cfg_rd_mask,
  input  logic                         rx_valid,
  input  logic [IDW-1:0]               rx_id,
  input  logic [LENW-1:0]              rx_dlc,
  input  logic [DATW-1:0]              rx_data,
  output logic                         rx_overrun,
  output logic                         q_valid,
  input  logic                         q_pop,
  output logic [IDW-1:0]               q_id,
  output logic [LENW-1:0]              q_dlc,
  output logic [DATW-1:0]              q_data,
  output logic [$clog2(NSLOT)-1:0]     q_slot,
  output logic [$clog2(DEPTH+1)-1:0]   q_count
);
  localparam int SW = $clog2(NSLOT);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [1:0] OP_ADD = 2'd1, OP_DEL = 2'd2, OP_READ = 2'd3;

  logic [IDW-1:0]   tid   [NSLOT];
  logic [IDW-1:0]   tmask [NSLOT];
  logic [NSLOT-1:0] used, hit_v, dup_v;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign used[g]  = |tid[g];
    assign hit_v[g] = used[g] && ((tmask[g] & tid[g]) == (tmask[g] & rx_id));
    assign dup_v[g] = used[g] && (tid[g] == cfg_id);
  end

  function automatic logic [SW-1:0] lowest(input logic [NSLOT-1:0] v);
    lowest = '0;
    for (int i = NSLOT-1; i >= 0; i--)
      if (v[i]) lowest = SW'(i);
  endfunction

  logic          dup_hit, has_free, rx_accept;
  logic [SW-1:0] dup_idx, free_idx, hit_idx;

  assign dup_hit   = |dup_v;
  assign dup_idx   = lowest(dup_v);
  assign has_free  = ~&used;
  assign free_idx  = lowest(~used);
  assign hit_idx   = lowest(hit_v);
  assign rx_accept = ~|used | |hit_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) begin
        tid[i]   <= '0;
        tmask[i] <= '0;
      end
      cfg_ack     <= 1'b0;
      cfg_err     <= 1'b0;
      cfg_slot    <= '0;
      cfg_rd_id   <= '0;
      cfg_rd_mask <= '0;
    end else begin
      cfg_ack  <= cfg_op != 2'd0;
      cfg_err  <= 1'b0;
      cfg_slot <= '0;
      case (cfg_op)
        OP_ADD: begin
          if (cfg_id == '0) cfg_err <= 1'b1;
          else if (dup_hit) cfg_slot <= dup_idx;
          else if (has_free) begin
            tid[free_idx]   <= cfg_id;
            tmask[free_idx] <= cfg_mask;
            cfg_slot        <= free_idx;
          end else cfg_err <= 1'b1;
        end
        OP_DEL: begin
          if (dup_hit) begin
            tid[dup_idx]   <= '0;
            tmask[dup_idx] <= '0;
            cfg_slot       <= dup_idx;
          end else cfg_err <= 1'b1;
        end
        OP_READ: begin
          cfg_rd_id   <= tid[cfg_sel];
          cfg_rd_mask <= tmask[cfg_sel];
          cfg_slot    <= cfg_sel;
        end
        default: ;
      endcase
    end
  end

  logic [IDW-1:0]  m_id   [DEPTH];
  logic [LENW-1:0] m_dlc  [DEPTH];
  logic [DATW-1:0] m_data [DEPTH];
  logic [SW-1:0]   m_slot [DEPTH];
  logic [PW-1:0]   wptr, rptr;
  logic            full, push, pop;

  assign full    = q_count == CW'(DEPTH);
  assign push    = rx_valid && rx_accept && !full;
  assign pop     = q_pop && q_valid;
  assign q_valid = q_count != '0;
  assign q_id    = m_id[rptr];
  assign q_dlc   = m_dlc[rptr];
  assign q_data  = m_data[rptr];
  assign q_slot  = m_slot[rptr];

  always_ff @(posedge clk) begin
    if (push) begin
      m_id[wptr]   <= rx_id;
      m_dlc[wptr]  <= rx_dlc;
      m_data[wptr] <= rx_data;
      m_slot[wptr] <= hit_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr       <= '0;
      rptr       <= '0;
      q_count    <= '0;
      rx_overrun <= 1'b0;
    end else begin
      if (push) wptr <= wptr + PW'(1);
      if (pop)  rptr <= rptr + PW'(1);
      q_count    <= q_count + CW'(push) - CW'(pop);
      rx_overrun <= rx_valid && rx_accept && full;
    end
  end
endmodule

module rx_accept_ring_chk #(
  parameter int NSLOT = 16,
  parameter int DEPTH = 8,
  parameter int IDW   = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [1:0]                 cfg_op,
  input logic [IDW-1:0]             cfg_id,
  input logic                       cfg_ack,
  input logic                       cfg_err,
  input logic [NSLOT-1:0]           used,
  input logic                       dup_hit,
  input logic                       rx_valid,
  input logic                       rx_accept,
  input logic                       q_pop,
  input logic [$clog2(DEPTH+1)-1:0] q_count,
  input logic                       rx_overrun
);
  localparam int CW = $clog2(DEPTH+1);

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(DEPTH));

  // R7
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_accept && q_count == CW'(DEPTH)) |=> (rx_overrun && q_count == CW'(DEPTH)));

  // R7
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> ($past(rx_valid) && $past(q_count) == CW'(DEPTH)));

  // R4
  table_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_op == 2'd1 && cfg_id != '0 && &used && !dup_hit) |=> (cfg_ack && cfg_err));

  // R8
  push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_accept && q_pop && q_count != '0 && q_count != CW'(DEPTH)) |=> $stable(q_count));

  // R10
  cfg_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_op != 2'd0) |=> cfg_ack);

  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == '0 && q_pop && !rx_valid) |=> (q_count == '0));
endmodule

bind rx_accept_ring rx_accept_ring_chk #(.NSLOT(NSLOT), .DEPTH(DEPTH), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_op(cfg_op), .cfg_id(cfg_id), .cfg_ack(cfg_ack),
  .cfg_err(cfg_err), .used(used), .dup_hit(dup_hit), .rx_valid(rx_valid),
  .rx_accept(rx_accept), .q_pop(q_pop), .q_count(q_count), .rx_overrun(rx_overrun)
);

// File: tb/sim_rx_accept_ring.sv
`timescale 1ns/1ps
module sim_rx_accept_ring;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [1:0]  cfg_op;
  logic [31:0] cfg_id, cfg_mask;
  logic [3:0]  cfg_sel;
  logic        cfg_ack, cfg_err;
  logic [3:0]  cfg_slot;
  logic [31:0] cfg_rd_id, cfg_rd_mask;
  logic        rx_valid;
  logic [31:0] rx_id;
  logic [3:0]  rx_dlc;
  logic [63:0] rx_data;
  logic        rx_overrun, q_valid, q_pop;
  logic [31:0] q_id;
  logic [3:0]  q_dlc;
  logic [63:0] q_data;
  logic [3:0]  q_slot, q_count;

  rx_accept_ring u0 (.*);

  logic [31:0] mid [16];
  logic [31:0] mmask [16];
  logic [31:0] qi [8];
  logic [3:0]  ql [8];
  logic [63:0] qd [8];
  logic [3:0]  qs [8];
  int qh, qn, nvec, nbad;
  bit done;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pay(input logic [31:0] id);
    return {id ^ 32'hA5A5_5A5A, ~id};
  endfunction

  task automatic model_match(input logic [31:0] id, output bit acc, output logic [3:0] sl);
    bit any = 0;
    acc = 0; sl = 0;
    for (int i = 0; i < 16; i++)
      if (mid[i] != 0) begin
        any = 1;
        if (!acc && ((mmask[i] & mid[i]) == (mmask[i] & id))) begin acc = 1; sl = 4'(i); end
      end
    if (!any) acc = 1;
  endtask

  task automatic do_cfg(input logic [1:0] op, input logic [31:0] id, input logic [31:0] mk,
                        input logic [3:0] sel, input string tag);
    bit eerr = 0; bit found = 0; int eslot = 0;
    if (op == 2'd1) begin
      if (id == 0) eerr = 1;
      else begin
        for (int i = 0; i < 16; i++) if (!found && mid[i] == id) begin found = 1; eslot = i; end
        if (!found) begin
          for (int i = 0; i < 16; i++) if (!found && mid[i] == 0) begin found = 1; eslot = i; end
          if (!found) eerr = 1;
          else begin mid[eslot] = id; mmask[eslot] = mk; end
        end
      end
    end else if (op == 2'd2) begin
      if (id != 0)
        for (int i = 0; i < 16; i++) if (!found && mid[i] == id) begin found = 1; eslot = i; end
      if (!found) eerr = 1;
      else begin mid[eslot] = 0; mmask[eslot] = 0; end
    end else eslot = sel;
    @(negedge clk);
    cfg_op = op; cfg_id = id; cfg_mask = mk; cfg_sel = sel;
    @(posedge clk); #1;
    chk({tag, " ack"}, cfg_ack, 1);
    chk({tag, " err"}, cfg_err, eerr);
    chk({tag, " slot"}, cfg_slot, eslot);
    if (op == 2'd3) begin
      chk({tag, " rd_id"}, cfg_rd_id, mid[sel]);
      chk({tag, " rd_mask"}, cfg_rd_mask, mmask[sel]);
    end
    @(negedge clk);
    cfg_op = 0;
  endtask

  task automatic push(input logic [31:0] id, input logic [3:0] dl, input string tag);
    bit acc; logic [3:0] sl; bit eovr;
    model_match(id, acc, sl);
    eovr = acc && qn == 8;
    @(negedge clk);
    rx_valid = 1; rx_id = id; rx_dlc = dl; rx_data = pay(id);
    @(posedge clk); #1;
    if (acc && qn < 8) begin
      qi[(qh+qn)%8] = id; ql[(qh+qn)%8] = dl; qd[(qh+qn)%8] = pay(id); qs[(qh+qn)%8] = sl; qn++;
    end
    chk({tag, " overrun"}, rx_overrun, eovr);
    chk({tag, " count"}, q_count, qn);
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic pop(input string tag);
    @(negedge clk);
    chk({tag, " q_valid"}, q_valid, qn != 0);
    if (qn != 0) begin
      chk({tag, " q_id"}, q_id, qi[qh]);
      chk({tag, " q_dlc"}, q_dlc, ql[qh]);
      chk({tag, " q_data"}, q_data, qd[qh]);
      chk({tag, " q_slot"}, q_slot, qs[qh]);
    end
    q_pop = 1;
    @(posedge clk); #1;
    if (qn != 0) begin qh = (qh + 1) % 8; qn--; end
    chk({tag, " count after pop"}, q_count, qn);
    @(negedge clk);
    q_pop = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [31:0] id;
    nvec = 0; nbad = 0; qh = 0; qn = 0; done = 0;
    for (int i = 0; i < 16; i++) begin mid[i] = 0; mmask[i] = 0; end
    rst_n = 0; cfg_op = 0; cfg_id = 0; cfg_mask = 0; cfg_sel = 0;
    rx_valid = 0; rx_id = 0; rx_dlc = 0; rx_data = 0; q_pop = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    chk("R1 q_valid", q_valid, 0);
    chk("R1 q_count", q_count, 0);
    chk("R1 cfg_ack", cfg_ack, 0);
    chk("R1 rx_overrun", rx_overrun, 0);
    do_cfg(2'd3, 0, 0, 4'd3, "R1 R9 read empty slot");

    // R3 empty table keeps all
    push(32'h0000_0123, 4'd8, "R3 std");
    push(32'h8001_2345, 4'd5, "R3 ext");
    push(32'h4000_0007, 4'd0, "R3 rtr");
    for (int k = 0; k < 3; k++) pop("R3 R6 drain");

    // R6 R7 fill past capacity
    for (int k = 0; k < 10; k++) push(32'h300 + k, 4'(k), "R7 fill");
    for (int k = 0; k < 8; k++) pop("R6 order");
    for (int k = 0; k < 12; k++) begin
      push(32'h400 + k, 4'(k + 1), "R6 wrap");
      pop("R6 wrap");
    end

    // R8 simultaneous push and pop
    push(32'h500, 4'd1, "R8 pre");
    push(32'h501, 4'd2, "R8 pre");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R8 head id", q_id, qi[qh]);
      q_pop = 1; rx_valid = 1; rx_id = 32'h510 + k; rx_dlc = 4'd3; rx_data = pay(32'h510 + k);
      @(posedge clk); #1;
      qh = (qh + 1) % 8;
      qi[(qh+qn-1)%8] = 32'h510 + k; ql[(qh+qn-1)%8] = 4'd3;
      qd[(qh+qn-1)%8] = pay(32'h510 + k); qs[(qh+qn-1)%8] = 0;
      chk("R8 count stable", q_count, qn);
      @(negedge clk); q_pop = 0; rx_valid = 0;
    end
    pop("R8 post");
    pop("R8 post");

    // R10 pop on empty ignored
    pop("R10 empty pop");
    push(32'h77, 4'd7, "R10 after empty pop");
    pop("R10 after empty pop");

    // R4 add
    for (int k = 0; k < 16; k++) do_cfg(2'd1, 32'h10 + k, 32'hFFFF_FFFF, 0, "R4 add");
    do_cfg(2'd1, 32'h15, 32'h0, 0, "R4 duplicate");
    do_cfg(2'd3, 0, 0, 4'd5, "R4 R9 duplicate unchanged");
    do_cfg(2'd1, 32'h99, 32'hFFFF_FFFF, 0, "R4 table full");
    do_cfg(2'd1, 32'h0, 32'hFFFF_FFFF, 0, "R4 zero id");
    // R5 remove
    do_cfg(2'd2, 32'h17, 0, 0, "R5 remove");
    do_cfg(2'd2, 32'h17, 0, 0, "R5 remove missing");
    do_cfg(2'd3, 0, 0, 4'd7, "R5 R9 cleared slot");
    do_cfg(2'd1, 32'h99, 32'h0000_0FF0, 0, "R4 lowest free");
    do_cfg(2'd3, 0, 0, 4'd7, "R9 readback");
    for (int k = 0; k < 16; k++) begin
      id = mid[k];
      do_cfg(2'd2, id, 0, 0, "R5 clear all");
    end

    // R10 frame judged against old table
    @(negedge clk);
    cfg_op = 2'd1; cfg_id = 32'h600; cfg_mask = 32'hFFFF_FFFF;
    rx_valid = 1; rx_id = 32'h601; rx_dlc = 4'd2; rx_data = pay(32'h601);
    @(posedge clk); #1;
    chk("R10 same-cycle frame kept", q_count, 1);
    chk("R10 ack", cfg_ack, 1);
    @(negedge clk); cfg_op = 0; rx_valid = 0;
    qi[(qh+qn)%8] = 32'h601; ql[(qh+qn)%8] = 4'd2; qd[(qh+qn)%8] = pay(32'h601); qs[(qh+qn)%8] = 0; qn++;
    mid[0] = 32'h600; mmask[0] = 32'hFFFF_FFFF;
    pop("R10 same-cycle pop");
    push(32'h601, 4'd2, "R3 no match dropped");
    chk("R3 no match q_valid", q_valid, 0);
    do_cfg(2'd2, 32'h600, 0, 0, "R5 remove");

    // R2 overlapping masks, first match
    do_cfg(2'd1, 32'h0000_0100, 32'h0000_07F0, 0, "R2 setup");
    do_cfg(2'd1, 32'h0000_0105, 32'hFFFF_FFFF, 0, "R2 setup");
    do_cfg(2'd1, 32'h8001_2345, 32'hFFFF_FFFF, 0, "R2 setup");
    do_cfg(2'd1, 32'h4000_0200, 32'hC000_07FF, 0, "R2 setup");
    do_cfg(2'd1, 32'h8000_0001, 32'h8000_0000, 0, "R2 setup");
    push(32'h0000_0105, 4'd1, "R2 shadowed");
    chk("R2 first match slot", q_slot, 0);
    pop("R2 shadowed");
    push(32'h8001_2345, 4'd1, "R2 ext exact");
    chk("R2 ext exact slot", q_slot, 2);
    pop("R2 ext exact");
    for (int k = 0; k < 128; k++) begin
      logic [31:0] low;
      low = 32'(k >> 2);
      id = {k[1], k[0], 30'h0} | ((low < 16) ? 32'h0FC + low : 32'h1F0 + low);
      push(id, 4'(k), "R2 sweep");
      pop("R2 sweep");
    end
    for (int k = 0; k < 16; k++) begin
      id = mid[k];
      if (id != 0) do_cfg(2'd2, id, 0, 0, "R5 clear all");
    end
    push(32'h0000_07FF, 4'd4, "R3 empty again");
    pop("R3 empty again");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule